// File: doc/BRIEF.md
# Majority-Clocked Three-Register Keystream Generator

This block produces a bit-serial keystream from three linear feedback shift registers whose combined state is 64 bits. A register moves forward only when its clocking tap agrees with the majority of the three clocking taps. As a result, two or three registers step on every irregular cycle. A frame is begun by a start pulse. The block clears all registers and captures a 64-bit key and a 22-bit frame number. It then shifts those 86 bits into the registers with regular clocking. After that it runs 100 irregular cycles whose output is thrown away, and then 228 irregular cycles that each deliver one keystream bit. These are the 114 bits for each link direction.

A second entry point, the direct-load pulse, writes a full 64-bit register state and moves at once to keystream output. It skips both the key schedule and the warm-up. This is how a state recovered elsewhere can be replayed. Combining the keystream with data is left to the surrounding logic.

Top module: `maj_lfsr_keygen`

## Requirements
- R1: After reset, `busy_o`, `ks_valid_o` and `ks_bit_o` are all 0. Whenever `ks_valid_o` is 0, `ks_bit_o` is 0.
- R2: A start pulse taken while idle keeps `busy_o` high for exactly 414 cycles, counted from the clock edge that samples the pulse. `ks_valid_o` is high only in the last 228 of those cycles, so the first valid bit appears 186 cycles after that edge.
- R3: A frame clears all three registers. It then clocks every register regularly for 86 cycles, XORing into each feedback bit the key bits `key_i[0]` to `key_i[63]` first and then `frame_i[0]` to `frame_i[21]`.
- R4: In warm-up and output cycles, a register steps only when its clocking bit equals the majority of the three clocking bits. The clocking bits are at positions 8, 10 and 10 of registers A, B and C.
- R5: Register lengths are 19 (A), 22 (B) and 23 (C). A step shifts toward the MSB and puts into bit 0 the XOR of taps {13,16,17,18} for A, {20,21} for B and {7,20,21,22} for C.
- R6: In each valid cycle, `ks_bit_o` is the XOR of the three register MSBs as they stand at the start of that cycle. The registers then step at the cycle's closing edge.
- R7: A direct-load pulse taken while idle sets register A to `state_i[18:0]`, B to `state_i[40:19]` and C to `state_i[63:41]`. It then gives 228 valid cycles starting with the next cycle.
- R8: While `busy_o` is high, both `start_i` and `load_i` are ignored. The keystream in progress is not changed.
- R9: If `start_i` and `load_i` are both high in the same idle cycle, the start pulse wins and a full 414-cycle frame runs.
- R10: The key and frame number are captured on the start edge. Later changes to `key_i` or `frame_i` do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a keyed frame (sampled while idle) |
| key_i | input | 64 | Session key, bit 0 injected first |
| frame_i | input | 22 | Frame number, injected after the key |
| load_i | input | 1 | Direct state load (sampled while idle) |
| state_i | input | 64 | Register state for direct load |
| busy_o | output | 1 | A frame or direct-load run is in progress |
| ks_valid_o | output | 1 | `ks_bit_o` carries a keystream bit |
| ks_bit_o | output | 1 | Keystream bit |

## Verification
The hardest situation to reach from the ports is a stray start or load request during a run. The request arrives with different key, frame and state values while the registers are mid-stream. The stimulus fires such requests during warm-up and again during output, and it scrambles `key_i` and `frame_i` right after every start edge. A clean keystream match then shows that nothing leaked. Random keys and states, along with the all-zero and all-one cases, exercise majority patterns in which two or three registers step. Every bit is compared against a bench model of the registers.

// File: rtl/mlk_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the majority-clocked keystream generator.
// Assumes the three register lengths add up to STATE_W.
package mlk_pkg;
    localparam int NREG    = 3;
    localparam int KEY_W   = 64;
    localparam int FRM_W   = 22;
    localparam int SEED_W  = KEY_W + FRM_W;
    localparam int MIX_CYC = 100;
    localparam int OUT_CYC = 228;
    localparam int STATE_W = 64;
    localparam int MAXLEN  = 23;

    localparam int REG_LEN [NREG] = '{19, 22, 23};
    localparam int CLK_POS [NREG] = '{8, 10, 10};
    localparam logic [MAXLEN-1:0] TAP_MASK [NREG] =
        '{23'h07_2000, 23'h30_0000, 23'h70_0080};

    typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_MIX, PH_OUT} phase_t;

    // Offset of register idx inside the packed state word.
    function automatic int reg_lo(input int idx);
        int s = 0;
        for (int k = 0; k < idx; k++) s += REG_LEN[k];
        return s;
    endfunction
endpackage

// File: rtl/mlk_lfsr.sv
`timescale 1ns/1ps
// One feedback shift register. It can be cleared, loaded in parallel, or
// stepped. A step shifts toward the MSB, and bit 0 takes the tap parity
// XOR the injected bit. Assumes clr has priority over ld, and ld over step.
module mlk_lfsr import mlk_pkg::*; #(
    parameter int              LEN  = 19,
    parameter logic [MAXLEN-1:0] TAPS = '0,
    parameter int              CPOS = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_i,
    input  logic           ld_i,
    input  logic [LEN-1:0] ld_val_i,
    input  logic           step_i,
    input  logic           inj_i,
    output logic           cbit_o,
    output logic           msb_o
);
    localparam logic [LEN-1:0] MASK = TAPS[LEN-1:0];

    logic [LEN-1:0] r;
    logic           fb;

    // Feedback: tap parity plus injected seed bit.
    assign fb     = (^(r & MASK)) ^ inj_i;
    assign cbit_o = r[CPOS];
    assign msb_o  = r[LEN-1];

    // State update in priority order: clear, load, step.
    always_ff @(posedge clk) begin
        if (!rst_n)      r <= '0;
        else if (clr_i)  r <= '0;
        else if (ld_i)   r <= ld_val_i;
        else if (step_i) r <= {r[LEN-2:0], fb};
    end

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (r == '0));
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !ld_i && !step_i) |=> $stable(r));
    // R5
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !ld_i && step_i) |=> (r[LEN-1:1] == $past(r[LEN-2:0])));
endmodule

// File: rtl/mlk_ctrl.sv
`timescale 1ns/1ps
// Phase sequencer: idle, seed load, warm-up, output. It captures key and
// frame number on a start and feeds them out one bit per load cycle, LSB
// first. Assumes start and load are only sampled while idle, with start winning.
module mlk_ctrl import mlk_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             load_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic [FRM_W-1:0] frame_i,
    output phase_t           phase_o,
    output logic             clr_o,
    output logic             ld_o,
    output logic             inj_o
);
    localparam int LONGEST = (OUT_CYC > SEED_W) ?
                             ((OUT_CYC > MIX_CYC) ? OUT_CYC : MIX_CYC) :
                             ((SEED_W > MIX_CYC) ? SEED_W : MIX_CYC);
    localparam int CNT_W = $clog2(LONGEST);
    localparam logic [CNT_W-1:0] SEED_LAST = CNT_W'(SEED_W - 1);
    localparam logic [CNT_W-1:0] MIX_LAST  = CNT_W'(MIX_CYC - 1);
    localparam logic [CNT_W-1:0] OUT_LAST  = CNT_W'(OUT_CYC - 1);

    phase_t              phase;
    logic [CNT_W-1:0]    cnt;
    logic [SEED_W-1:0]   seed;
    logic                idle;

    assign idle    = (phase == PH_IDLE);
    assign clr_o   = idle & start_i;
    assign ld_o    = idle & ~start_i & load_i;
    assign inj_o   = (phase == PH_LOAD) & seed[0];
    assign phase_o = phase;

    // Phase, cycle counter and seed shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            seed  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (start_i) begin
                        phase <= PH_LOAD;
                        seed  <= {frame_i, key_i};
                    end else if (load_i) begin
                        phase <= PH_OUT;
                    end
                end
                PH_LOAD: begin
                    seed <= seed >> 1;
                    if (cnt == SEED_LAST) begin
                        phase <= PH_MIX;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                PH_MIX: begin
                    if (cnt == MIX_LAST) begin
                        phase <= PH_OUT;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                default: begin
                    if (cnt == OUT_LAST) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    // R2
    start_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start_i) |=> (phase == PH_LOAD) && (cnt == '0));
    // R7
    direct_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !start_i && load_i) |=> (phase == PH_OUT) && (cnt == '0));
    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_MIX && start_i) |=> (phase != PH_LOAD));
    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= OUT_LAST);
endmodule

// File: rtl/maj_lfsr_keygen.sv
`timescale 1ns/1ps
// Majority-clocked three-register keystream generator (top). It holds the
// sequencer and the registers, forms the majority vote, and gates the
// output. Assumes the register lengths add up to STATE_W.
module maj_lfsr_keygen import mlk_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [KEY_W-1:0]   key_i,
    input  logic [FRM_W-1:0]   frame_i,
    input  logic               load_i,
    input  logic [STATE_W-1:0] state_i,
    output logic               busy_o,
    output logic               ks_valid_o,
    output logic               ks_bit_o
);
    phase_t            phase;
    logic              clr, ld, inj;
    logic [NREG-1:0]   cbit, msb, step;
    logic              vote, irregular;

    mlk_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_i  (load_i),
        .key_i   (key_i),
        .frame_i (frame_i),
        .phase_o (phase),
        .clr_o   (clr),
        .ld_o    (ld),
        .inj_o   (inj)
    );

    // Majority of the clocking bits, used only in irregular phases.
    assign vote      = ($countones(cbit) > (NREG / 2));
    assign irregular = (phase == PH_MIX) || (phase == PH_OUT);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam int LO = reg_lo(g);
        // Step enable: always during seed load, by vote otherwise.
        assign step[g] = (phase == PH_LOAD) | (irregular & (cbit[g] == vote));
        mlk_lfsr #(
            .LEN  (REG_LEN[g]),
            .TAPS (TAP_MASK[g]),
            .CPOS (CLK_POS[g])
        ) u_lfsr (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (clr),
            .ld_i     (ld),
            .ld_val_i (state_i[LO +: REG_LEN[g]]),
            .step_i   (step[g]),
            .inj_i    (inj),
            .cbit_o   (cbit[g]),
            .msb_o    (msb[g])
        );
    end

    assign busy_o     = (phase != PH_IDLE);
    assign ks_valid_o = (phase == PH_OUT);
    assign ks_bit_o   = ks_valid_o & (^msb);

    // R4
    two_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irregular |-> ($countones(step) >= 2));
    // R1
    quiet_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ks_valid_o |-> !ks_bit_o);
    // R6
    valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid_o |-> busy_o);
    // R2
    end_after_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(ks_valid_o));
endmodule

// File: tb/test_maj_lfsr_keygen.sv
`timescale 1ns/1ps
module test_maj_lfsr_keygen;
    localparam int PRE_FRAME = 186;
    localparam int NOUT      = 228;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start_i = 0;
    logic [63:0] key_i = '0;
    logic [21:0] frame_i = '0;
    logic        load_i = 0;
    logic [63:0] state_i = '0;
    logic        busy_o, ks_valid_o, ks_bit_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [18:0] ma;
    logic [21:0] mb;
    logic [22:0] mc;
    bit exp_ks [NOUT];

    always #2 clk = ~clk;

    maj_lfsr_keygen i_maj_lfsr_keygen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
        .frame_i(frame_i), .load_i(load_i), .state_i(state_i),
        .busy_o(busy_o), .ks_valid_o(ks_valid_o), .ks_bit_o(ks_bit_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference step: R4 majority, R5 taps, R3 injection.
    function automatic void m_clk(input bit irr, input bit inj);
        bit fa, fb, fc, v;
        fa = ma[13] ^ ma[16] ^ ma[17] ^ ma[18] ^ inj;
        fb = mb[20] ^ mb[21] ^ inj;
        fc = mc[7] ^ mc[20] ^ mc[21] ^ mc[22] ^ inj;
        v  = (int'(ma[8]) + int'(mb[10]) + int'(mc[10])) >= 2;
        if (!irr || ma[8]  == v) ma = {ma[17:0], fa};
        if (!irr || mb[10] == v) mb = {mb[20:0], fb};
        if (!irr || mc[10] == v) mc = {mc[21:0], fc};
    endfunction

    // R6: the bit comes from the state before each step.
    function automatic void m_emit();
        for (int i = 0; i < NOUT; i++) begin
            exp_ks[i] = ma[18] ^ mb[21] ^ mc[22];
            m_clk(1'b1, 1'b0);
        end
    endfunction

    function automatic void m_frame(input logic [63:0] k, input logic [21:0] f);
        ma = '0; mb = '0; mc = '0;
        for (int i = 0; i < 86; i++) m_clk(1'b0, (i < 64) ? k[i] : f[i-64]);
        for (int i = 0; i < 100; i++) m_clk(1'b1, 1'b0);
        m_emit();
    endfunction

    function automatic void m_direct(input logic [63:0] s);
        ma = s[18:0]; mb = s[40:19]; mc = s[63:41];
        m_emit();
    endfunction

    // Observes one run; optionally fires stray start/load requests (R8).
    task automatic watch(input int pre, input bit disturb, input string req);
        int busy_bad = 0, val_bad = 0, bit_bad = 0, first = -1;
        int act_b = 0, exp_b = 0;
        for (int i = 0; i < pre + NOUT; i++) begin
            @(negedge clk);
            if (!busy_o) busy_bad++;
            if (ks_valid_o != (i >= pre)) val_bad++;
            if (i >= pre && ks_bit_o != exp_ks[i-pre]) begin
                bit_bad++;
                if (first < 0) begin
                    first = i - pre; act_b = ks_bit_o; exp_b = exp_ks[i-pre];
                end
            end
            if (disturb && (i == 40 || i == pre + 60)) begin
                start_i = 1; load_i = 1;
                key_i = {$urandom, $urandom}; frame_i = 22'($urandom);
                state_i = {$urandom, $urandom};
            end else if (disturb) begin
                start_i = 0; load_i = 0;
            end
        end
        @(negedge clk);
        check(busy_bad == 0 && busy_o == 0, req, "busy window (bad cycles)",
              busy_bad + int'(busy_o), 0);
        check(val_bad == 0 && ks_valid_o == 0 && ks_bit_o == 0, req,
              "valid window (bad cycles)", val_bad, 0);
        check(bit_bad == 0, req, $sformatf("keystream bit %0d", first), act_b, exp_b);
    endtask

    task automatic frame_run(input logic [63:0] k, input logic [21:0] f,
                             input bit with_load, input bit disturb, input string req);
        m_frame(k, f);
        @(negedge clk);
        key_i = k; frame_i = f; start_i = 1;
        load_i = with_load; state_i = {$urandom, $urandom};
        @(posedge clk); #1;
        start_i = 0; load_i = 0;
        key_i = ~k; frame_i = ~f;   // R10: changes after capture
        watch(PRE_FRAME, disturb, req);
    endtask

    task automatic direct_run(input logic [63:0] s, input bit disturb, input string req);
        m_direct(s);
        @(negedge clk);
        state_i = s; load_i = 1;
        @(posedge clk); #1;
        load_i = 0; state_i = ~s;
        watch(0, disturb, req);
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1
        check(busy_o == 0, "R1", "busy after reset", busy_o, 0);
        check(ks_valid_o == 0, "R1", "valid after reset", ks_valid_o, 0);
        check(ks_bit_o == 0, "R1", "bit after reset", ks_bit_o, 0);

        // R2 R3 R4 R5 R6: directed keys, then random keys with R10 scrambling
        frame_run(64'h0, 22'h0, 0, 0, "R3");
        frame_run({64{1'b1}}, {22{1'b1}}, 0, 0, "R5");
        frame_run(64'h1, 22'h0, 0, 0, "R3");
        for (int n = 0; n < 3; n++)
            frame_run({$urandom, $urandom}, 22'($urandom), 0, 0, "R10");
        // R7 direct load
        direct_run({64{1'b1}}, 0, "R7");
        for (int n = 0; n < 3; n++)
            direct_run({$urandom, $urandom}, 0, "R4");
        // R8 stray requests while busy
        frame_run({$urandom, $urandom}, 22'($urandom), 0, 1, "R8");
        direct_run({$urandom, $urandom}, 1, "R8");
        // R9 start and load together
        frame_run({$urandom, $urandom}, 22'($urandom), 1, 0, "R9");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule